// File: doc/BRIEF.md
# Parallel Device Port DMA Controller

This block sits between a processor bus and a 16-bit parallel peripheral. Software sees a small set of 16-bit registers at fixed byte offsets. A control word, written at offset 0x00, sets three function lines that run to the device, sets the interrupt enable, starts DMA and clears sticky event flags. A status word is read at the same offset. It reports those flags, the live device inputs and whether the controller is idle. A separate pulse register at offset 0x06 sets or clears the interrupt enable without touching the other control state.

The DMA engine moves one word for each cycle request. The request comes from the device, or from a forced-cycle bit in the control word. Each word is a single request on a plain request/acknowledge memory handshake. After each transfer the engine advances a word address and counts down a range register. When the range counter wraps past zero, DMA ends and the end-of-range flag is raised. A bus error or a bus timeout on the handshake ends DMA and raises its own flag. The interrupt line is high while the enable is set and any event flag is set.

Top module: `pdma_ctrl`

## Requirements
- R1: After reset the status word (offset 0x00) reads 0x0080, and irq, mem_req, dev_go, dev_mclr and dev_fcn are all 0.
- R2: A write at 0x14 loads the low 16 bits of the DMA word address. A write at 0x1C loads the upper HI_W bits. A write at 0x16 loads the range counter. Reads at 0x18 and 0x20 return the low and high address (high zero-extended). A read at 0x16 returns the range. Every other read offset except 0x00 returns 0. A control write stores bit 6 as the interrupt enable and bits 3..1 as the function latches. dev_fcn[2:0] equals control bits 3..1, and status bits 6 and 3..1 read them back.
- R3: A control write with bit 12 set is a master clear. All event flags, the interrupt enable, the function latches, DMA enable and any open memory request are cleared. dev_mclr is high for exactly the next cycle. The other bits of that word have no effect, and the address and range registers keep their values.
- R4: A control write with bit 0 set (and bit 12 clear) enables DMA, so status bit 7 reads 0. It drives dev_go high for exactly the next cycle and clears the bus-error and bus-timeout flags.
- R5: Writing 1 to control bit 15, 14 or 13 clears, respectively, the end-of-range flag (status bit 15), the attention flag (bit 14) or the parity flag (bit 12). If the flag's event occurs in the same cycle, the flag stays set.
- R6: Status bit 14 sets one cycle after dev_attn goes from 0 to 1. Status bit 13 shows dev_attn delayed by one cycle. Status bit 12 sets after any cycle with dev_perr high. Status bits 11, 10 and 9 show dev_stat[0], dev_stat[1] and dev_stat[2] live.
- R7: A pulse-register write (offset 0x06) with bit 6 set sets the interrupt enable. With only bit 5 set it clears the enable. Bit 6 wins if both are set, other bits have no effect, and a read at 0x06 returns 0.
- R8: While DMA is enabled and no request is open, a dev_cyc pulse raises mem_req in the next cycle, with mem_addr = {high, low} address. A control write with bit 8 set does the same if DMA is already enabled or bit 0 is set in the same word. mem_req then holds, with a stable address, until mem_ack, mem_berr or mem_tmo. Cycle requests made while a request is open or DMA is disabled are dropped. mem_wr equals the function latch at control bit 1.
- R9: mem_ack on an open request ends it, increments the full address (carrying into the high part) and decrements the range. A register write in the same cycle overrides the part it targets. An ack with range 0 leaves range 0xFFFF, disables DMA (status bit 7 reads 1) and sets the end-of-range flag.
- R10: mem_berr on an open request ends it without counting, sets status bit 5 and disables DMA. mem_tmo (without mem_berr) does the same with status bit 4. mem_berr takes priority over mem_tmo and mem_ack.
- R11: irq is high exactly when the interrupt enable is set and at least one of end-of-range, attention, parity, bus-error or bus-timeout flags is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | OFF_W | Byte offset of the write |
| bus_wdata | input | 16 | Write data |
| bus_raddr | input | OFF_W | Byte offset of the read |
| bus_rdata | output | 16 | Read data (combinational) |
| dev_fcn | output | 3 | Function latches to the device |
| dev_go | output | 1 | One-cycle start pulse to the device |
| dev_mclr | output | 1 | One-cycle master-clear pulse to the device |
| dev_attn | input | 1 | Device attention level |
| dev_stat | input | 3 | Device status lines A, B, C |
| dev_perr | input | 1 | Device parity error indication |
| dev_cyc | input | 1 | Device request for one DMA word |
| mem_req | output | 1 | Memory word transfer request |
| mem_wr | output | 1 | Transfer direction, 1 = write to memory |
| mem_addr | output | 16+HI_W | Word address of the transfer |
| mem_ack | input | 1 | Transfer completed |
| mem_berr | input | 1 | Transfer ended with bus error |
| mem_tmo | input | 1 | Transfer ended with bus timeout |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check several properties on every cycle:
- the one-cycle start and clear pulses;
- that an open memory request holds with a steady address while no response arrives;
- that a request never exists without DMA enabled;
- that an ack at range zero ends DMA with the end-of-range flag set;
- that attention edges and bus errors always leave their flags set.

Only the bench's scenarios can show the values seen through the register map. These are the read-back offsets and the range wrap to 0xFFFF, the carry of the address into its high part, and the precedence between a flag clear and a same-cycle event. They also include the pulse-register set-over-clear rule and the words ignored under master clear.

// File: rtl/pdma_ctrl.sv
module pdma_ctrl #(
  parameter int HI_W  = 8,
  parameter int OFF_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [OFF_W-1:0]  bus_addr,
  input  logic [15:0]       bus_wdata,
  input  logic [OFF_W-1:0]  bus_raddr,
  output logic [15:0]       bus_rdata,
  output logic [2:0]        dev_fcn,
  output logic              dev_go,
  output logic              dev_mclr,
  input  logic              dev_attn,
  input  logic [2:0]        dev_stat,
  input  logic              dev_perr,
  input  logic              dev_cyc,
  output logic              mem_req,
  output logic              mem_wr,
  output logic [15+HI_W:0]  mem_addr,
  input  logic              mem_ack,
  input  logic              mem_berr,
  input  logic              mem_tmo,
  output logic              irq
);
  localparam int AW = 16 + HI_W;
  localparam logic [OFF_W-1:0] OFF_CTL = OFF_W'(6'h00);
  localparam logic [OFF_W-1:0] OFF_PLS = OFF_W'(6'h06);
  localparam logic [OFF_W-1:0] OFF_WLO = OFF_W'(6'h14);
  localparam logic [OFF_W-1:0] OFF_RNG = OFF_W'(6'h16);
  localparam logic [OFF_W-1:0] OFF_RLO = OFF_W'(6'h18);
  localparam logic [OFF_W-1:0] OFF_WHI = OFF_W'(6'h1C);
  localparam logic [OFF_W-1:0] OFF_RHI = OFF_W'(6'h20);
  localparam logic [AW-1:0]    ONE     = AW'(1);

  logic          dmaf, attf, attq, perr, berr, terr, ie, en, req, go_q, mclr_q;
  logic [2:0]    fcn;
  logic [AW-1:0] addr, addr_nx;
  logic [15:0]   rng, rng_nx, status;

  wire ctl_wr = bus_wr && (bus_addr == OFF_CTL);
  wire pls_wr = bus_wr && (bus_addr == OFF_PLS);
  wire lo_wr  = bus_wr && (bus_addr == OFF_WLO);
  wire hi_wr  = bus_wr && (bus_addr == OFF_WHI);
  wire rng_wr = bus_wr && (bus_addr == OFF_RNG);

  wire mclr_w  = ctl_wr && bus_wdata[12];
  wire ctl_ok  = ctl_wr && !bus_wdata[12];
  wire go_w    = ctl_ok && bus_wdata[0];
  wire force_w = ctl_ok && bus_wdata[8] && (en || bus_wdata[0]);
  wire bad_w   = req && (mem_berr || mem_tmo);
  wire good_w  = req && mem_ack && !mem_berr && !mem_tmo;
  wire last_w  = good_w && (rng == 16'd0);
  wire launch  = !req && !mclr_w && ((en && dev_cyc) || force_w);

  always_comb begin
    addr_nx = good_w ? addr + ONE : addr;
    if (lo_wr) addr_nx[15:0]    = bus_wdata;
    if (hi_wr) addr_nx[AW-1:16] = bus_wdata[HI_W-1:0];
  end

  assign rng_nx = rng_wr ? bus_wdata : (good_w ? rng - 16'd1 : rng);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {dmaf, attf, attq, perr, berr, terr, ie, en, req, go_q, mclr_q} <= '0;
      fcn  <= '0;
      addr <= '0;
      rng  <= '0;
    end else begin
      attq   <= dev_attn;
      go_q   <= go_w;
      mclr_q <= mclr_w;
      addr   <= addr_nx;
      rng    <= rng_nx;
      if (mclr_w) begin
        {dmaf, attf, perr, berr, terr, ie, en, req} <= '0;
        fcn <= '0;
      end else begin
        dmaf <= last_w | (dmaf & ~(ctl_wr & bus_wdata[15]));
        attf <= (dev_attn & ~attq) | (attf & ~(ctl_wr & bus_wdata[14]));
        perr <= dev_perr | (perr & ~(ctl_wr & bus_wdata[13]));
        berr <= (req & mem_berr) | (berr & ~go_w);
        terr <= (req & mem_tmo & ~mem_berr) | (terr & ~go_w);
        if (pls_wr && bus_wdata[6])      ie <= 1'b1;
        else if (pls_wr && bus_wdata[5]) ie <= 1'b0;
        else if (ctl_wr)                 ie <= bus_wdata[6];
        if (ctl_wr) fcn <= bus_wdata[3:1];
        if (go_w)                   en <= 1'b1;
        else if (bad_w || last_w)   en <= 1'b0;
        if (bad_w || good_w) req <= 1'b0;
        else if (launch)     req <= 1'b1;
      end
    end
  end

  assign status = {dmaf, attf, attq, perr, dev_stat[0], dev_stat[1], dev_stat[2],
                   1'b0, ~en, ie, berr, terr, fcn, 1'b0};

  always_comb begin
    case (bus_raddr)
      OFF_CTL: bus_rdata = status;
      OFF_RNG: bus_rdata = rng;
      OFF_RLO: bus_rdata = addr[15:0];
      OFF_RHI: bus_rdata = 16'(addr[AW-1:16]);
      default: bus_rdata = 16'h0000;
    endcase
  end

  assign dev_fcn  = fcn;
  assign dev_go   = go_q;
  assign dev_mclr = mclr_q;
  assign mem_req  = req;
  assign mem_wr   = fcn[0];
  assign mem_addr = addr;
  assign irq      = ie & (dmaf | attf | perr | berr | terr);
endmodule

// File: rtl/pdma_ctrl_chk.sv
module pdma_ctrl_chk #(
  parameter int HI_W  = 8,
  parameter int OFF_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [OFF_W-1:0]  bus_addr,
  input logic [15:0]       bus_wdata,
  input logic              dev_go,
  input logic              dev_mclr,
  input logic              dev_attn,
  input logic              mem_req,
  input logic [15+HI_W:0]  mem_addr,
  input logic              mem_ack,
  input logic              mem_berr,
  input logic              mem_tmo,
  input logic              en,
  input logic              dmaf,
  input logic              attf,
  input logic              attq,
  input logic              berr,
  input logic [15:0]       rng
);
  wire ctl_wr = bus_wr && (bus_addr == '0);
  wire mclr_w = ctl_wr && bus_wdata[12];

  a_r4_go_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && bus_wdata[0] && !bus_wdata[12]) |=> (dev_go && en));

  a_r3_master_clear: assert property (@(posedge clk) disable iff (!rst_n)
    mclr_w |=> (dev_mclr && !dev_go && !mem_req && !en && !dmaf && !attf && !berr));

  a_r8_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !mem_berr && !mem_tmo && !bus_wr) |=> (mem_req && $stable(mem_addr)));

  a_r8_req_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> en);

  a_r9_end_of_range: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && !mem_berr && !mem_tmo && rng == 16'd0 && !bus_wr) |=> (dmaf && !en && !mem_req));

  a_r6_attn_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_attn && !attq && !mclr_w) |=> attf);

  a_r10_bus_error: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_berr && !bus_wr) |=> (berr && !en && !mem_req));
endmodule

bind pdma_ctrl pdma_ctrl_chk #(.HI_W(HI_W), .OFF_W(OFF_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .dev_go(dev_go), .dev_mclr(dev_mclr), .dev_attn(dev_attn), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_berr(mem_berr), .mem_tmo(mem_tmo),
  .en(en), .dmaf(dmaf), .attf(attf), .attq(attq), .berr(berr), .rng(rng));

// File: tb/pdma_ctrl_tb_top.sv
`timescale 1ns/100ps
module pdma_ctrl_tb_top;
  localparam int HI_W = 8;
  localparam int OFF_W = 6;
  localparam int AW = 16 + HI_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 0, dev_attn = 0, dev_perr = 0, dev_cyc = 0;
  logic mem_ack = 0, mem_berr = 0, mem_tmo = 0;
  logic [OFF_W-1:0] bus_addr = '0, bus_raddr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic [2:0] dev_fcn, dev_stat = '0;
  logic dev_go, dev_mclr, mem_req, mem_wr, irq;
  logic [AW-1:0] mem_addr;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pdma_ctrl #(.HI_W(HI_W), .OFF_W(OFF_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_raddr(bus_raddr), .bus_rdata(bus_rdata), .dev_fcn(dev_fcn), .dev_go(dev_go),
    .dev_mclr(dev_mclr), .dev_attn(dev_attn), .dev_stat(dev_stat), .dev_perr(dev_perr),
    .dev_cyc(dev_cyc), .mem_req(mem_req), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_berr(mem_berr), .mem_tmo(mem_tmo), .irq(irq));

  // reference state, built from the requirements
  logic m_dmaf, m_attf, m_attq, m_perr, m_berr, m_terr, m_ie, m_en, m_req, m_go, m_mclr;
  logic [2:0] m_fcn;
  logic [AW-1:0] m_addr;
  logic [15:0] m_rng;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_dmaf, m_attf, m_attq, m_perr, m_berr, m_terr, m_ie, m_en, m_req, m_go, m_mclr} = '0;
      m_fcn = '0; m_addr = '0; m_rng = '0;
    end else begin
      logic cw, pw, mc, g, bad, ok, lst, fc, lau, edge_a;
      logic [AW-1:0] na;
      cw = bus_wr && bus_addr == 6'h00;
      pw = bus_wr && bus_addr == 6'h06;
      mc = cw && bus_wdata[12];
      g  = cw && !bus_wdata[12] && bus_wdata[0];
      bad = m_req && (mem_berr || mem_tmo);
      ok  = m_req && mem_ack && !mem_berr && !mem_tmo;
      lst = ok && m_rng == 16'd0;
      fc  = cw && !bus_wdata[12] && bus_wdata[8] && (m_en || bus_wdata[0]);
      lau = !m_req && !mc && ((m_en && dev_cyc) || fc);
      edge_a = dev_attn && !m_attq;
      na = ok ? m_addr + 1 : m_addr;
      if (bus_wr && bus_addr == 6'h14) na[15:0] = bus_wdata;
      if (bus_wr && bus_addr == 6'h1C) na[AW-1:16] = bus_wdata[HI_W-1:0];
      if (bus_wr && bus_addr == 6'h16) m_rng = bus_wdata;
      else if (ok) m_rng = m_rng - 16'd1;
      m_addr = na;
      m_go = g; m_mclr = mc;
      if (mc) begin
        {m_dmaf, m_attf, m_perr, m_berr, m_terr, m_ie, m_en, m_req} = '0;
        m_fcn = '0;
      end else begin
        m_dmaf = lst || (m_dmaf && !(cw && bus_wdata[15]));
        m_attf = edge_a || (m_attf && !(cw && bus_wdata[14]));
        m_perr = dev_perr || (m_perr && !(cw && bus_wdata[13]));
        m_berr = (m_req && mem_berr) || (m_berr && !g);
        m_terr = (m_req && mem_tmo && !mem_berr) || (m_terr && !g);
        if (pw && bus_wdata[6]) m_ie = 1;
        else if (pw && bus_wdata[5]) m_ie = 0;
        else if (cw) m_ie = bus_wdata[6];
        if (cw) m_fcn = bus_wdata[3:1];
        if (g) m_en = 1; else if (bad || lst) m_en = 0;
        if (bad || ok) m_req = 0; else if (lau) m_req = 1;
      end
      m_attq = dev_attn;
    end
  end

  function automatic logic [15:0] exp_rd(logic [OFF_W-1:0] a);
    case (a)
      6'h00: return {m_dmaf, m_attf, m_attq, m_perr, dev_stat[0], dev_stat[1], dev_stat[2],
                     1'b0, !m_en, m_ie, m_berr, m_terr, m_fcn, 1'b0};
      6'h16: return m_rng;
      6'h18: return m_addr[15:0];
      6'h20: return 16'(m_addr[AW-1:16]);
      default: return 16'h0000;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " rdata"}, 32'(bus_rdata), 32'(exp_rd(bus_raddr)));
    chk({tag, " R11 irq"}, 32'(irq), 32'(m_ie & (m_dmaf | m_attf | m_perr | m_berr | m_terr)));
    chk({tag, " R8 mem_req"}, 32'(mem_req), 32'(m_req));
    chk({tag, " R8 mem_addr"}, 32'(mem_addr), 32'(m_addr));
    chk({tag, " R8 mem_wr"}, 32'(mem_wr), 32'(m_fcn[0]));
    chk({tag, " R2 dev_fcn"}, 32'(dev_fcn), 32'(m_fcn));
    chk({tag, " R4 dev_go"}, 32'(dev_go), 32'(m_go));
    chk({tag, " R3 dev_mclr"}, 32'(dev_mclr), 32'(m_mclr));
  endtask

  // caller sets inputs just after a falling edge; one clock passes
  task automatic step(string tag);
    #0.5;
    check_all(tag);
    @(posedge clk);
    @(negedge clk);
    bus_wr = 0; dev_cyc = 0; mem_ack = 0; mem_berr = 0; mem_tmo = 0; dev_perr = 0;
  endtask

  task automatic wr(logic [OFF_W-1:0] a, logic [15:0] d, string tag);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    step(tag);
  endtask

  task automatic rd_chk(logic [OFF_W-1:0] a, logic [15:0] exp, string tag);
    bus_raddr = a;
    #0.2;
    chk(tag, 32'(bus_rdata), 32'(exp));
  endtask

  function automatic logic [OFF_W-1:0] pick_off(int k);
    case (k % 9)
      0, 1: return 6'h00;
      2: return 6'h06;
      3: return 6'h14;
      4: return 6'h16;
      5: return 6'h18;
      6: return 6'h1C;
      7: return 6'h20;
      default: return 6'h0A;
    endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #0.5;
    // R1 reset state
    rd_chk(6'h00, 16'h0080, "R1 status after reset");
    chk("R1 irq", 32'(irq), 0);
    chk("R1 mem_req", 32'(mem_req), 0);
    chk("R1 dev_go", 32'(dev_go), 0);
    chk("R1 dev_mclr", 32'(dev_mclr), 0);
    @(negedge clk);

    // R2 register map
    wr(6'h14, 16'h1234, "R2 lo");
    wr(6'h1C, 16'hAB56, "R2 hi");
    wr(6'h16, 16'h0002, "R2 range");
    rd_chk(6'h18, 16'h1234, "R2 read lo");
    rd_chk(6'h20, 16'h0056, "R2 read hi");
    rd_chk(6'h14, 16'h0000, "R2 write-only lo reads 0");
    rd_chk(6'h16, 16'h0002, "R2 read range");
    @(negedge clk);
    wr(6'h00, 16'h004E, "R2 ctl");
    rd_chk(6'h00, 16'h00CE, "R2 status ie+fcn");
    chk("R2 dev_fcn", 32'(dev_fcn), 7);
    @(negedge clk);

    // R7 pulse register
    wr(6'h06, 16'h0020, "R7 clear ie");
    rd_chk(6'h00, 16'h008E, "R7 ie cleared");
    @(negedge clk);
    wr(6'h06, 16'h0060, "R7 set wins");
    rd_chk(6'h00, 16'h00CE, "R7 ie set");
    rd_chk(6'h06, 16'h0000, "R7 reads 0");
    @(negedge clk);

    // R4 GO, R8 transfers, R9 end of range
    wr(6'h00, 16'h004F, "R4 go");
    chk("R4 dev_go pulse", 32'(dev_go), 1);
    step("R4 go ends");
    chk("R4 dev_go one cycle", 32'(dev_go), 0);
    for (int w = 0; w < 3; w++) begin
      dev_cyc = 1; step("R8 request");
      chk("R8 mem_req raised", 32'(mem_req), 1);
      dev_cyc = 1; step("R8 dropped while open");
      mem_ack = 1; step("R9 ack");
    end
    rd_chk(6'h16, 16'hFFFF, "R9 range wrapped");
    rd_chk(6'h00, 16'h80CE, "R9 end-of-range, ready");
    rd_chk(6'h18, 16'h1237, "R9 address advanced");
    chk("R11 irq on end-of-range", 32'(irq), 1);
    dev_cyc = 1; step("R8 ignored when disabled");
    chk("R8 no request when disabled", 32'(mem_req), 0);

    // R5 clears, R6 inputs
    wr(6'h00, 16'h804E, "R5 clear dmaf");
    rd_chk(6'h00, 16'h00CE, "R5 dmaf cleared");
    chk("R11 irq off", 32'(irq), 0);
    @(negedge clk);
    dev_attn = 1; step("R6 attn rise");
    dev_perr = 1; dev_stat = 3'b001; step("R6 perr");
    rd_chk(6'h00, 16'h78CE, "R6 attf, level, perr, stat A");
    @(negedge clk);
    dev_perr = 1; wr(6'h00, 16'h604E, "R5 clear vs same-cycle parity");
    rd_chk(6'h00, 16'h38CE, "R5 parity kept, attf cleared");
    @(negedge clk);
    dev_stat = 3'b000; dev_attn = 0;
    wr(6'h00, 16'h204E, "R5 clear parity");

    // R10 bus error and timeout
    wr(6'h00, 16'h014F, "R10 go with forced cycle");
    chk("R8 forced cycle", 32'(mem_req), 1);
    mem_berr = 1; mem_tmo = 1; mem_ack = 1; step("R10 berr wins");
    rd_chk(6'h00, 16'h00EE, "R10 berr flag, ready");
    @(negedge clk);
    wr(6'h00, 16'h004F, "R10 go clears errors");
    dev_cyc = 1; step("R10 req");
    mem_tmo = 1; step("R10 timeout");
    rd_chk(6'h00, 16'h00DE, "R10 terr flag");
    @(negedge clk);

    // R9 carry into high part
    wr(6'h14, 16'hFFFF, "R9 lo all ones");
    wr(6'h00, 16'h004F, "R9 go");
    dev_cyc = 1; step("R9 req");
    mem_ack = 1; step("R9 ack carry");
    rd_chk(6'h20, 16'h0057, "R9 carry into high");
    rd_chk(6'h18, 16'h0000, "R9 low wrapped");
    @(negedge clk);

    // R3 master clear, other bits ignored
    dev_cyc = 1; step("R3 open request");
    wr(6'h00, 16'h1141, "R3 master clear");
    chk("R3 dev_mclr", 32'(dev_mclr), 1);
    chk("R3 no go", 32'(dev_go), 0);
    chk("R3 request dropped", 32'(mem_req), 0);
    rd_chk(6'h00, 16'h0080, "R3 status cleared");
    rd_chk(6'h20, 16'h0057, "R3 address kept");
    @(negedge clk);
    step("R3 pulse ends");
    chk("R3 dev_mclr one cycle", 32'(dev_mclr), 0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      bus_wr = ($urandom % 4) == 0;
      bus_addr = pick_off($urandom);
      bus_wdata = 16'($urandom);
      if (bus_addr == 6'h00 && ($urandom % 16) != 0) bus_wdata[12] = 1'b0;
      if (bus_addr == 6'h16) bus_wdata = bus_wdata & 16'h0007;
      dev_cyc  = ($urandom % 3) == 0;
      mem_ack  = ($urandom % 2) == 0;
      mem_berr = ($urandom % 40) == 0;
      mem_tmo  = ($urandom % 40) == 0;
      dev_perr = ($urandom % 50) == 0;
      if (($urandom % 8) == 0) dev_attn = ~dev_attn;
      dev_stat = 3'($urandom);
      bus_raddr = pick_off($urandom);
      step("random");
    end
    finish_run();
  end
endmodule